// File: doc/BRIEF.md
# Keyed External Clock Prescaler

This block makes a clock for an external pin. It takes one of two free-running input clocks, the system bus clock or an oscillator clock, and divides it by a programmable value plus one. One 32-bit control register, written and read from the bus clock domain, sets all of its behaviour. The divider stays stopped until a 4-bit unlock field in that register holds the single code 4'hA. This guards against a stray write that would start a clock on a board net.

Two other conditions gate the output. A debug-suspend input turns the clock off unless the register's continue-on-suspend bit is set. A pin-function enable input must be high before any clock reaches the pin. Whenever the clock is stopped, the output rests low and the divide counter is cleared. When the clock is allowed again, it begins with a complete first period.

Source switching uses a cross-coupled pair of enables, one flop pair clocked in each source domain, so the internal clock never carries a short pulse. A new divide value is captured only at the end of an output period.

Top module: `keyed_clk_prescaler`

## Requirements
- R1: After reset, a read at byte offset CTRL_OFFSET (default 8'h28) returns 32'h5000_0000, and `eclk_out` stays low.
- R2: The output toggles only while bits 31:28 of the control register equal 4'hA. With any other value, `eclk_out` makes no rising edge.
- R3: Bit 24 selects the source: 0 selects `bus_clk` and 1 selects `osc_clk`. The two internal source enables are never both high.
- R4: With divide value N ≥ 1 in bits 15:0, the output period is N+1 source periods. The output is high for (N+2)/2 source periods (integer division) and low for the rest.
- R5: With N = 0, `eclk_out` follows the selected source clock, high for half a source period in each source period.
- R6: With bit 23 at 0, asserting `dbg_suspend` stops the output. With bit 23 at 1, the output keeps toggling during suspend.
- R7: While `pin_func_en` is 0, `eclk_out` makes no rising edge.
- R8: Bits 27:25 and 22:16 always read as 0, and writes to them have no effect. Writing 32'hFFFF_FFFF reads back as 32'hF180_FFFF.
- R9: A new divide value written during an output period does not shorten or stretch that period. It takes effect from the next period.
- R10: After the clock is stopped and allowed again, the first output period is a full period of the current divide value, starting with its high phase.
- R11: A write at any other offset leaves the control register unchanged, and a read at any other offset returns 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| bus_clk | input | 1 | System bus clock; register clock and source 0 |
| osc_clk | input | 1 | Oscillator clock; source 1 |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write strobe, sampled on `bus_clk` |
| reg_addr | input | ADDR_W | Byte offset of the access |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for `reg_addr` (combinational) |
| pin_func_en | input | 1 | Pin placed in clock-output function |
| dbg_suspend | input | 1 | Debug suspend request |
| eclk_out | output | 1 | Divided clock to the pin |

## Verification
Two situations are hard to reach from the ports: a register write that lands in the middle of an output period, and a stop that lands in the middle of a high phase. The bench waits for a rising edge of `eclk_out`, issues the write a few cycles later, and then times the following edges. This checks that the current period keeps the old value and that the restart begins cleanly. For random divide values on either source, the bench converts the measured edge times into source periods and compares them with values it computes from N.

// File: rtl/keyed_clk_prescaler_pkg.sv
`timescale 1ns/1ps
package keyed_clk_prescaler_pkg;
  localparam logic [3:0] KEY_OPEN  = 4'hA;
  localparam logic [3:0] KEY_RESET = 4'h5;
  localparam int KEY_MSB = 31;
  localparam int KEY_LSB = 28;
  localparam int SRC_BIT = 24;
  localparam int COS_BIT = 23;

  // number of source periods the output spends high for divide value n (n >= 1)
  function automatic logic [31:0] high_len(input logic [31:0] n);
    return (n + 32'd2) >> 1;
  endfunction

  // decides whether the output clock may run at all
  function automatic logic clk_allowed(input logic [3:0] key, input logic pin_on,
                                       input logic susp, input logic cont_susp);
    return (key == KEY_OPEN) && pin_on && (!susp || cont_susp);
  endfunction
endpackage

// File: rtl/keyed_clk_prescaler_regs.sv
`timescale 1ns/1ps
module keyed_clk_prescaler_regs
  import keyed_clk_prescaler_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter logic [ADDR_W-1:0] CTRL_OFFSET = 8'h28,
  parameter int DIV_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr,
  input  logic [ADDR_W-1:0] addr,
  input  logic [31:0]       wdata,
  output logic [31:0]       rdata,
  input  logic              pin_on,
  input  logic              susp,
  output logic              src_osc,
  output logic [DIV_W-1:0]  div_n,
  output logic              run_req
);
  logic [3:0] key_q;
  logic       cos_q;
  logic       hit;
  logic       unused_rsv;

  assign hit        = (addr == CTRL_OFFSET);
  assign unused_rsv = ^{wdata[27:25], wdata[22:DIV_W]};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      key_q   <= KEY_RESET;
      src_osc <= 1'b0;
      cos_q   <= 1'b0;
      div_n   <= '0;
    end else if (wr && hit) begin
      key_q   <= wdata[KEY_MSB:KEY_LSB];
      src_osc <= wdata[SRC_BIT];
      cos_q   <= wdata[COS_BIT];
      div_n   <= wdata[DIV_W-1:0];
    end
  end

  // gating decision registered in the bus domain before crossing
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) run_req <= 1'b0;
    else        run_req <= clk_allowed(key_q, pin_on, susp, cos_q);
  end

  always_comb begin
    rdata = '0;
    if (hit) begin
      rdata[KEY_MSB:KEY_LSB] = key_q;
      rdata[SRC_BIT]         = src_osc;
      rdata[COS_BIT]         = cos_q;
      rdata[DIV_W-1:0]       = div_n;
    end
  end
endmodule

// File: rtl/keyed_clk_prescaler_mux.sv
`timescale 1ns/1ps
module keyed_clk_prescaler_mux (
  input  logic clk_a,
  input  logic clk_b,
  input  logic rst_n,
  input  logic sel_b,
  output logic gclk,
  output logic a_on,
  output logic b_on
);
  logic a_s1, b_s1;

  // each side enables itself only after the other side has dropped,
  // and every enable changes while its own clock is low
  always_ff @(negedge clk_a or negedge rst_n) begin
    if (!rst_n) begin
      a_s1 <= 1'b0;
      a_on <= 1'b0;
    end else begin
      a_s1 <= !sel_b && !b_on;
      a_on <= a_s1;
    end
  end

  always_ff @(negedge clk_b or negedge rst_n) begin
    if (!rst_n) begin
      b_s1 <= 1'b0;
      b_on <= 1'b0;
    end else begin
      b_s1 <= sel_b && !a_on;
      b_on <= b_s1;
    end
  end

  assign gclk = (clk_a & a_on) | (clk_b & b_on);
endmodule

// File: rtl/keyed_clk_prescaler_div.sv
`timescale 1ns/1ps
module keyed_clk_prescaler_div
  import keyed_clk_prescaler_pkg::*;
#(
  parameter int DIV_W = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic             gclk,
  input  logic             rst_n,
  input  logic             run_req,
  input  logic [DIV_W-1:0] cfg_n,
  output logic             run_s,
  output logic             started,
  output logic [DIV_W-1:0] cnt,
  output logic [DIV_W-1:0] act_n,
  output logic             div_q,
  output logic             clk_out
);
  logic [SYNC_STAGES-1:0] sync_q;
  logic                   pass_en;
  logic                   period_end;
  logic [DIV_W:0]         next_idx;

  always_ff @(posedge gclk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= {sync_q[SYNC_STAGES-2:0], run_req};
  end
  assign run_s = sync_q[SYNC_STAGES-1];

  assign period_end = !started || (cnt == act_n);
  assign next_idx   = {1'b0, cnt} + 1'b1;

  always_ff @(posedge gclk or negedge rst_n) begin
    if (!rst_n) begin
      started <= 1'b0;
      cnt     <= '0;
      act_n   <= '0;
      div_q   <= 1'b0;
    end else if (!run_s) begin
      started <= 1'b0;
      cnt     <= '0;
      act_n   <= cfg_n;
      div_q   <= 1'b0;
    end else if (period_end) begin
      started <= 1'b1;
      cnt     <= '0;
      act_n   <= cfg_n;
      div_q   <= (cfg_n != '0);
    end else begin
      cnt     <= next_idx[DIV_W-1:0];
      div_q   <= (32'(next_idx) < high_len(32'(act_n)));
    end
  end

  // pass-through enable changes only while gclk is low
  always_ff @(negedge gclk or negedge rst_n) begin
    if (!rst_n) pass_en <= 1'b0;
    else        pass_en <= run_s && started && (act_n == '0);
  end

  assign clk_out = div_q | (gclk & pass_en);
endmodule

// File: rtl/keyed_clk_prescaler.sv
`timescale 1ns/1ps
module keyed_clk_prescaler #(
  parameter int ADDR_W = 8,
  parameter logic [ADDR_W-1:0] CTRL_OFFSET = 8'h28,
  parameter int DIV_W = 16
) (
  input  logic              bus_clk,
  input  logic              osc_clk,
  input  logic              rst_n,
  input  logic              reg_wr,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [31:0]       reg_wdata,
  output logic [31:0]       reg_rdata,
  input  logic              pin_func_en,
  input  logic              dbg_suspend,
  output logic              eclk_out
);
  // named internal events, observed by the bound checker
  logic             src_osc;
  logic [DIV_W-1:0] div_n;
  logic             run_req;
  logic             gclk;
  logic             bus_on;
  logic             osc_on;
  logic             run_s;
  logic             started;
  logic [DIV_W-1:0] cnt;
  logic [DIV_W-1:0] act_n;
  logic             div_q;

  keyed_clk_prescaler_regs #(.ADDR_W(ADDR_W), .CTRL_OFFSET(CTRL_OFFSET), .DIV_W(DIV_W)) u_regs (
    .clk(bus_clk), .rst_n(rst_n), .wr(reg_wr), .addr(reg_addr), .wdata(reg_wdata),
    .rdata(reg_rdata), .pin_on(pin_func_en), .susp(dbg_suspend),
    .src_osc(src_osc), .div_n(div_n), .run_req(run_req)
  );

  keyed_clk_prescaler_mux u_mux (
    .clk_a(bus_clk), .clk_b(osc_clk), .rst_n(rst_n), .sel_b(src_osc),
    .gclk(gclk), .a_on(bus_on), .b_on(osc_on)
  );

  keyed_clk_prescaler_div #(.DIV_W(DIV_W)) u_div (
    .gclk(gclk), .rst_n(rst_n), .run_req(run_req), .cfg_n(div_n),
    .run_s(run_s), .started(started), .cnt(cnt), .act_n(act_n),
    .div_q(div_q), .clk_out(eclk_out)
  );
endmodule

// File: rtl/keyed_clk_prescaler_chk.sv
`timescale 1ns/1ps
module keyed_clk_prescaler_chk #(
  parameter int DIV_W = 16
) (
  input logic             bus_clk,
  input logic             gclk,
  input logic             rst_n,
  input logic             bus_on,
  input logic             osc_on,
  input logic             run_s,
  input logic             started,
  input logic [DIV_W-1:0] cnt,
  input logic [DIV_W-1:0] act_n,
  input logic [31:0]      reg_rdata,
  input logic             eclk_out
);
  a_r3_one_source: assert property (@(posedge bus_clk) disable iff (!rst_n)
    $onehot0({bus_on, osc_on}));

  a_r8_reserved_zero: assert property (@(posedge bus_clk) disable iff (!rst_n)
    (reg_rdata & 32'h0E7F_0000) == 32'h0);

  a_r2_idle_low: assert property (@(posedge gclk) disable iff (!rst_n)
    !run_s |=> !eclk_out);

  a_r4_count_bound: assert property (@(posedge gclk) disable iff (!rst_n)
    started |-> (cnt <= act_n));

  a_r9_value_held: assert property (@(posedge gclk) disable iff (!rst_n)
    (run_s && started && (cnt != act_n)) |=> $stable(act_n));
endmodule

bind keyed_clk_prescaler keyed_clk_prescaler_chk #(.DIV_W(DIV_W)) u_chk (
  .bus_clk(bus_clk), .gclk(gclk), .rst_n(rst_n), .bus_on(bus_on), .osc_on(osc_on),
  .run_s(run_s), .started(started), .cnt(cnt), .act_n(act_n),
  .reg_rdata(reg_rdata), .eclk_out(eclk_out)
);

// File: tb/keyed_clk_prescaler_test.sv
`timescale 1ns/1ps
module keyed_clk_prescaler_test;
  localparam int BUS_PERIOD = 10;
  localparam int OSC_PERIOD = 14;
  localparam logic [7:0] OFFS = 8'h28;

  logic bus_clk = 0, osc_clk = 0, rst_n = 0;
  logic reg_wr = 0;
  logic [7:0] reg_addr = OFFS;
  logic [31:0] reg_wdata = 0;
  logic [31:0] reg_rdata;
  logic pin_func_en = 0, dbg_suspend = 0;
  logic eclk_out;

  int checks = 0, fails = 0, edges = 0;

  always #(BUS_PERIOD/2) bus_clk = ~bus_clk;
  always #(OSC_PERIOD/2) osc_clk = ~osc_clk;
  always @(posedge eclk_out) edges++;

  keyed_clk_prescaler uut (
    .bus_clk(bus_clk), .osc_clk(osc_clk), .rst_n(rst_n), .reg_wr(reg_wr),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .pin_func_en(pin_func_en), .dbg_suspend(dbg_suspend), .eclk_out(eclk_out)
  );

  function automatic logic [31:0] ctrl(input logic [3:0] key, input logic osc,
                                       input logic cos, input logic [15:0] n);
    return {key, 3'b000, osc, cos, 7'b0, n};
  endfunction
  function automatic int exp_hi2(input int n);   // high time in half source periods
    return (n == 0) ? 1 : 2 * ((n + 2) / 2);
  endfunction

  task automatic check(input bit ok, input string tag, input longint act, input longint expv);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, expv);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge bus_clk); reg_addr = a; reg_wdata = d; reg_wr = 1;
    @(negedge bus_clk); reg_wr = 0; reg_addr = OFFS;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    @(negedge bus_clk); reg_addr = a; #1 d = reg_rdata;
    reg_addr = OFFS;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge bus_clk);
  endtask

  // expects no rising edge over a window after gating settles
  task automatic expect_quiet(input string tag);
    int e0;
    idle(8);
    e0 = edges;
    idle(60);
    check(edges == e0 && eclk_out == 0, tag, edges - e0, 0);
  endtask

  task automatic expect_running(input string tag);
    int e0;
    idle(8);
    e0 = edges;
    idle(200);
    check(edges > e0, tag, edges - e0, 1);
  endtask

  task automatic measure(input int n, input bit osc, input string tag);
    time t0, t1, t2;
    int p;
    p = osc ? OSC_PERIOD : BUS_PERIOD;
    repeat (3) @(posedge eclk_out);
    t0 = $time; @(negedge eclk_out); t1 = $time; @(posedge eclk_out); t2 = $time;
    check(((t1 - t0) * 2 / p) == exp_hi2(n), {tag, " high"}, (t1 - t0) * 2 / p, exp_hi2(n));
    check(((t2 - t0) / p) == n + 1, {tag, " period"}, (t2 - t0) / p, n + 1);
  endtask

  initial begin
    #(BUS_PERIOD * 150000);
    fails++; checks++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    logic [31:0] d;
    void'($urandom(32'd4242));
    idle(3); rst_n = 1; idle(3);

    // R1 reset state
    rd(OFFS, d);
    check(d == 32'h5000_0000, "R1 reset value", d, 32'h5000_0000);
    pin_func_en = 1;
    wr(8'h00, 32'h0);
    expect_quiet("R1 output low after reset");

    // R2 key
    wr(OFFS, ctrl(4'h5, 0, 0, 16'd3)); expect_quiet("R2 key 5 blocks");
    wr(OFFS, ctrl(4'hB, 0, 0, 16'd3)); expect_quiet("R2 key B blocks");
    wr(OFFS, ctrl(4'h0, 0, 0, 16'd3)); expect_quiet("R2 key 0 blocks");
    wr(OFFS, ctrl(4'hA, 0, 0, 16'd3)); expect_running("R2 key A runs");

    // R8 reserved bits
    wr(OFFS, 32'hFFFF_FFFF);
    rd(OFFS, d);
    check(d == 32'hF180_FFFF, "R8 reserved readback", d, 32'hF180_FFFF);
    expect_quiet("R2 key F blocks");

    // R11 other offsets
    wr(OFFS, ctrl(4'h5, 1, 1, 16'h1234));
    wr(8'h2C, ctrl(4'hA, 0, 0, 16'd3));
    rd(OFFS, d);
    check(d == ctrl(4'h5, 1, 1, 16'h1234), "R11 other offset write ignored", d, ctrl(4'h5, 1, 1, 16'h1234));
    rd(8'h2C, d);
    check(d == 0, "R11 other offset reads zero", d, 0);

    // R5 pass-through on both sources
    wr(OFFS, ctrl(4'hA, 0, 0, 16'd0)); measure(0, 0, "R5 bus N=0");
    wr(OFFS, ctrl(4'hA, 1, 0, 16'd0)); measure(0, 1, "R5 osc N=0");

    // R4 / R3 random divide values and sources
    for (int i = 0; i < 10; i++) begin
      int n; bit s;
      n = 1 + ($urandom % 12);
      s = $urandom % 2;
      wr(OFFS, ctrl(4'hA, s, $urandom % 2, 16'(n)));
      measure(n, s, s ? "R4 R3 osc random" : "R4 R3 bus random");
    end
    wr(OFFS, ctrl(4'hA, 0, 0, 16'd255)); measure(255, 0, "R4 bus N=255");
    wr(OFFS, ctrl(4'hA, 1, 0, 16'd1));   measure(1, 1, "R4 osc N=1");

    // R9 change mid period on bus source
    begin
      time t0, t1, t2;
      wr(OFFS, ctrl(4'hA, 0, 0, 16'd9));
      repeat (3) @(posedge eclk_out);
      t0 = $time;
      wr(OFFS, ctrl(4'hA, 0, 0, 16'd3));
      @(posedge eclk_out); t1 = $time;
      @(posedge eclk_out); t2 = $time;
      check((t1 - t0) / BUS_PERIOD == 10, "R9 old period completes", (t1 - t0) / BUS_PERIOD, 10);
      check((t2 - t1) / BUS_PERIOD == 4, "R9 new period next", (t2 - t1) / BUS_PERIOD, 4);
    end

    // R10 restart from fresh period
    begin
      time t0, t1, t2;
      wr(OFFS, ctrl(4'hA, 0, 0, 16'd7));
      repeat (2) @(posedge eclk_out);
      #(BUS_PERIOD);
      wr(OFFS, ctrl(4'h5, 0, 0, 16'd7));
      expect_quiet("R10 stopped");
      wr(OFFS, ctrl(4'hA, 0, 0, 16'd7));
      @(posedge eclk_out); t0 = $time;
      @(negedge eclk_out); t1 = $time;
      @(posedge eclk_out); t2 = $time;
      check((t1 - t0) / BUS_PERIOD == 4, "R10 first high full", (t1 - t0) / BUS_PERIOD, 4);
      check((t2 - t0) / BUS_PERIOD == 8, "R10 first period full", (t2 - t0) / BUS_PERIOD, 8);
    end

    // R6 suspend
    wr(OFFS, ctrl(4'hA, 1, 0, 16'd2));
    dbg_suspend = 1; expect_quiet("R6 suspend stops");
    wr(OFFS, ctrl(4'hA, 1, 1, 16'd2));
    expect_running("R6 continue on suspend");
    measure(2, 1, "R6 suspended divide");
    dbg_suspend = 0;

    // R7 pin function
    pin_func_en = 0; expect_quiet("R7 pin off stops");
    pin_func_en = 1; measure(2, 1, "R7 pin back on");

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule